// File: doc/BRIEF.md
# Low-g / High-g Acceleration Event Detector

This block watches a stream of signed 14-bit acceleration samples on three axes and decides whether the device is falling (every selected axis close to zero g) or moving hard (some selected axis far from zero g). Each axis sample is turned into a magnitude and compared with a threshold. The threshold is either one shared coarse value or a separate fine value for each axis. The per-axis results are combined with an AND in freefall mode or an OR in motion mode.

A debounce counter requires the combined condition to hold for a programmed number of samples before the event flag rises. When the condition lapses, the counter either steps down by one or drops to zero, as configured. The flag can be latched until software reads the source register, or it can follow the detection result sample by sample. The source register records which axes tripped and the sign of each of those axes.

The block advances only on a sample-valid strobe. The status-read strobe is the only other input that can change its state.

Top module: `ffmt_detector`

## Requirements
- R1: The magnitude of an axis is the absolute value of its two's-complement sample. The most negative code (-8192) maps to 8191.
- R2: When `cfg_thr_sel` is 0, every axis uses `thr_common` shifted left by 6 bits (value x64) as its threshold. When it is 1, each axis uses its own 13-bit `thr_x`/`thr_y`/`thr_z`.
- R3: In motion mode (`cfg_motion`=1), the condition is true when at least one enabled axis has a magnitude strictly greater than its threshold.
- R4: In freefall mode (`cfg_motion`=0), the condition is true when every enabled axis has a magnitude strictly less than its threshold. With no axis enabled (`cfg_axis_en`=0) the condition is never true.
- R5: On a strobed sample where the condition holds, the debounce counter increments, saturating at `dbc_limit`. A detection occurs when the counter then equals `dbc_limit`, so a limit of 0 detects on the first qualifying sample and a limit of N detects on the Nth consecutive qualifying sample.
- R6: With `cfg_dbclr`=0, a strobed sample where the condition is false decrements the counter by one, never below zero.
- R7: With `cfg_dbclr`=1, a strobed sample where the condition is false clears the counter to zero.
- R8: With `cfg_latch`=1, a detection sets `evt_active`, which then stays set until a cycle with `src_read`=1. A read in the same cycle as a new detection leaves the flag set.
- R9: With `cfg_latch`=0, every strobed sample sets `evt_active` to that sample's detection result, and `src_read` has no effect.
- R10: Bit 0/1/2 of `src_axis_evt` belongs to the X/Y/Z axis. On a detection, an axis bit is set when that axis is enabled and passed its comparison (above in motion mode, below in freefall mode). For each such axis, the matching `src_axis_neg` bit holds that sample's sign (1 = negative). In latched mode the axis bits accumulate over detections. Both fields clear together with `evt_active`.
- R11: In a cycle without `smp_vld`, neither the counter nor the outputs change, whatever the sample values are; the only exception is a latched-mode read.
- R12: After a synchronous reset, `evt_active`, `src_axis_evt`, `src_axis_neg` and the counter are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe: the three axis samples are valid this cycle |
| smp_x | input | 14 | X-axis sample, two's complement |
| smp_y | input | 14 | Y-axis sample, two's complement |
| smp_z | input | 14 | Z-axis sample, two's complement |
| cfg_motion | input | 1 | 1 = motion (OR of above-threshold), 0 = freefall (AND of below-threshold) |
| cfg_axis_en | input | 3 | Axis enables, bit 0 = X, 1 = Y, 2 = Z |
| cfg_latch | input | 1 | 1 = event latched until read, 0 = real-time |
| cfg_dbclr | input | 1 | Debounce on lapse: 1 = clear, 0 = decrement |
| cfg_thr_sel | input | 1 | 1 = per-axis thresholds, 0 = shared threshold |
| thr_common | input | 7 | Shared threshold, weight 64 counts per step |
| thr_x | input | 13 | X-axis threshold in sample counts |
| thr_y | input | 13 | Y-axis threshold in sample counts |
| thr_z | input | 13 | Z-axis threshold in sample counts |
| dbc_limit | input | 8 | Debounce sample count |
| src_read | input | 1 | Source-register read strobe |
| evt_active | output | 1 | Event-active flag |
| src_axis_evt | output | 3 | Per-axis event bits |
| src_axis_neg | output | 3 | Per-axis polarity bits, 1 = negative |

## Verification
The hardest state to reach from the ports is a debounce counter that has been partly drained in decrement mode and then climbs back to the limit. A related case is a latched read that lands in exactly the cycle of a new detection. Long directed runs of alternating qualifying and failing samples with small limits, and reads placed on the detecting sample, drive the block into both. Most of the run is a seeded random walk over modes, limits, thresholds and edge-value samples (including -8192), with gaps in the strobe, and a behavioural model is compared on every clock.

// File: rtl/ffmt_pkg.sv
package ffmt_pkg;
  localparam int NAX = 3;

  typedef enum logic {
    DB_DEC = 1'b0,
    DB_CLR = 1'b1
  } db_mode_e;
endpackage

// File: rtl/ffmt_axis_cmp.sv
module ffmt_axis_cmp #(
  parameter int DATA_W = 14,
  localparam int MAG_W = DATA_W - 1
) (
  input  logic [DATA_W-1:0] smp,
  input  logic [MAG_W-1:0]  thr,
  output logic              above,
  output logic              below,
  output logic              neg
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] flipped;
  logic [MAG_W-1:0]  mag;

  always_comb begin
    flipped = ~smp + 1'b1;
    if (smp == MOST_NEG)
      mag = '1;
    else if (smp[DATA_W-1])
      mag = flipped[MAG_W-1:0];
    else
      mag = smp[MAG_W-1:0];
    above = mag > thr;
    below = mag < thr;
    neg   = smp[DATA_W-1];
  end
endmodule

// File: rtl/ffmt_debounce.sv
module ffmt_debounce
  import ffmt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             cond,
  input  db_mode_e         mode,
  input  logic [CNT_W-1:0] limit,
  output logic             detect
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    if (cond)
      cnt_nx = (cnt >= limit) ? limit : cnt + 1'b1;
    else if (mode == DB_CLR)
      cnt_nx = '0;
    else
      cnt_nx = (cnt != '0) ? cnt - 1'b1 : '0;
    detect = vld && cond && (cnt_nx == limit);
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (vld)
      cnt <= cnt_nx;
  end

  p_sat_r5: assert property (@(posedge clk) disable iff (rst)
    vld && cond |=> cnt <= $past(limit));
  p_dec_r6: assert property (@(posedge clk) disable iff (rst)
    vld && !cond && mode == DB_DEC && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
  p_clr_r7: assert property (@(posedge clk) disable iff (rst)
    vld && !cond && mode == DB_CLR |=> cnt == '0);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(cnt));
endmodule

// File: rtl/ffmt_event_reg.sv
module ffmt_event_reg #(
  parameter int NAX = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld,
  input  logic           detect,
  input  logic           latch,
  input  logic           rd,
  input  logic [NAX-1:0] cur_axis,
  input  logic [NAX-1:0] cur_neg,
  output logic           ev,
  output logic [NAX-1:0] ev_axis,
  output logic [NAX-1:0] ev_neg
);
  logic [NAX-1:0] pol_now;
  assign pol_now = cur_neg & cur_axis;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev      <= 1'b0;
      ev_axis <= '0;
      ev_neg  <= '0;
    end else if (latch) begin
      if (vld && detect) begin
        ev <= 1'b1;
        if (ev && !rd) begin
          ev_axis <= ev_axis | cur_axis;
          ev_neg  <= (ev_neg & ~cur_axis) | pol_now;
        end else begin
          ev_axis <= cur_axis;
          ev_neg  <= pol_now;
        end
      end else if (rd) begin
        ev      <= 1'b0;
        ev_axis <= '0;
        ev_neg  <= '0;
      end
    end else if (vld) begin
      ev      <= detect;
      ev_axis <= detect ? cur_axis : '0;
      ev_neg  <= detect ? pol_now : '0;
    end
  end

  p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
    latch && ev && !rd |=> ev);
  p_rd_same_r8: assert property (@(posedge clk) disable iff (rst)
    latch && vld && detect && rd |=> ev);
  p_rt_follow_r9: assert property (@(posedge clk) disable iff (rst)
    !latch && vld |=> ev == $past(detect));
  p_src_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !ev |-> ev_axis == '0 && ev_neg == '0);
endmodule

// File: rtl/ffmt_detector.sv
module ffmt_detector
  import ffmt_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CTH_W  = 7,
  parameter int CNT_W  = 8,
  localparam int MAG_W = DATA_W - 1,
  localparam int SHIFT = MAG_W - CTH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_x,
  input  logic [DATA_W-1:0] smp_y,
  input  logic [DATA_W-1:0] smp_z,
  input  logic              cfg_motion,
  input  logic [NAX-1:0]    cfg_axis_en,
  input  logic              cfg_latch,
  input  logic              cfg_dbclr,
  input  logic              cfg_thr_sel,
  input  logic [CTH_W-1:0]  thr_common,
  input  logic [MAG_W-1:0]  thr_x,
  input  logic [MAG_W-1:0]  thr_y,
  input  logic [MAG_W-1:0]  thr_z,
  input  logic [CNT_W-1:0]  dbc_limit,
  input  logic              src_read,
  output logic              evt_active,
  output logic [NAX-1:0]    src_axis_evt,
  output logic [NAX-1:0]    src_axis_neg
);
  logic [DATA_W-1:0] smp_a [NAX];
  logic [MAG_W-1:0]  thr_a [NAX];
  logic [MAG_W-1:0]  thr_shared;
  logic [NAX-1:0]    above, below, neg, qual;
  logic              cond, detect;
  db_mode_e          db_mode;

  assign smp_a[0] = smp_x;
  assign smp_a[1] = smp_y;
  assign smp_a[2] = smp_z;
  assign thr_shared = {thr_common, {SHIFT{1'b0}}};
  assign db_mode = cfg_dbclr ? DB_CLR : DB_DEC;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    always_comb begin
      unique case (a)
        0:       thr_a[a] = cfg_thr_sel ? thr_x : thr_shared;
        1:       thr_a[a] = cfg_thr_sel ? thr_y : thr_shared;
        default: thr_a[a] = cfg_thr_sel ? thr_z : thr_shared;
      endcase
    end

    ffmt_axis_cmp #(.DATA_W(DATA_W)) cmp_i (
      .smp   (smp_a[a]),
      .thr   (thr_a[a]),
      .above (above[a]),
      .below (below[a]),
      .neg   (neg[a])
    );

    assign qual[a] = cfg_axis_en[a] && (cfg_motion ? above[a] : below[a]);
  end

  assign cond = cfg_motion ? (|qual)
                           : ((|cfg_axis_en) && (&(below | ~cfg_axis_en)));

  ffmt_debounce #(.CNT_W(CNT_W)) dbc_i (
    .clk    (clk),
    .rst    (rst),
    .vld    (smp_vld),
    .cond   (cond),
    .mode   (db_mode),
    .limit  (dbc_limit),
    .detect (detect)
  );

  ffmt_event_reg #(.NAX(NAX)) evr_i (
    .clk      (clk),
    .rst      (rst),
    .vld      (smp_vld),
    .detect   (detect),
    .latch    (cfg_latch),
    .rd       (src_read),
    .cur_axis (qual),
    .cur_neg  (neg),
    .ev       (evt_active),
    .ev_axis  (src_axis_evt),
    .ev_neg   (src_axis_neg)
  );

  p_ff_none_r4: assert property (@(posedge clk) disable iff (rst)
    smp_vld && !cfg_motion && cfg_axis_en == '0 |-> !detect);
  p_src_subset_r10: assert property (@(posedge clk) disable iff (rst)
    smp_vld && detect && !cfg_latch |=> (src_axis_evt & ~$past(cfg_axis_en)) == '0);
endmodule

// File: tb/ffmt_detector_tb_top.sv
`timescale 1ns/1ps
module ffmt_detector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic signed [13:0] sx = '0, sy = '0, sz = '0;
  logic cfg_motion = 1'b0, cfg_latch = 1'b0, cfg_dbclr = 1'b0, cfg_thr_sel = 1'b0;
  logic [2:0] cfg_axis_en = '0;
  logic [6:0] thr_common = '0;
  logic [12:0] thr_x = '0, thr_y = '0, thr_z = '0;
  logic [7:0] dbc_limit = '0;
  logic src_read = 1'b0;
  logic evt_active;
  logic [2:0] src_axis_evt, src_axis_neg;

  int checks = 0, fails = 0;
  string cur_req = "R12";
  bit started = 0;

  int m_cnt = 0;
  bit m_ev = 0;
  bit [2:0] m_ax = 0, m_ng = 0;

  always #2.5 clk = ~clk;

  ffmt_detector dut_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .smp_x(sx), .smp_y(sy), .smp_z(sz),
    .cfg_motion(cfg_motion), .cfg_axis_en(cfg_axis_en), .cfg_latch(cfg_latch),
    .cfg_dbclr(cfg_dbclr), .cfg_thr_sel(cfg_thr_sel), .thr_common(thr_common),
    .thr_x(thr_x), .thr_y(thr_y), .thr_z(thr_z), .dbc_limit(dbc_limit),
    .src_read(src_read), .evt_active(evt_active),
    .src_axis_evt(src_axis_evt), .src_axis_neg(src_axis_neg)
  );

  function automatic int magnitude(int v);
    if (v == -8192) return 8191;
    return (v < 0) ? -v : v;
  endfunction

  // behavioural reference model, advanced at every rising edge
  always @(posedge clk) begin
    int smp[3];
    int thr[3];
    bit q[3];
    bit lo[3];
    bit cnd, det, any_en, all_lo;
    bit [2:0] qa, na;
    smp[0] = int'(sx); smp[1] = int'(sy); smp[2] = int'(sz);
    thr[0] = cfg_thr_sel ? int'(thr_x) : int'(thr_common) * 64;
    thr[1] = cfg_thr_sel ? int'(thr_y) : int'(thr_common) * 64;
    thr[2] = cfg_thr_sel ? int'(thr_z) : int'(thr_common) * 64;
    any_en = 0; all_lo = 1; qa = 0; na = 0;
    for (int a = 0; a < 3; a++) begin
      lo[a] = magnitude(smp[a]) < thr[a];
      q[a] = cfg_axis_en[a] && (cfg_motion ? (magnitude(smp[a]) > thr[a]) : lo[a]);
      if (cfg_axis_en[a]) begin
        any_en = 1;
        if (!lo[a]) all_lo = 0;
      end
      qa[a] = q[a];
      na[a] = q[a] && smp[a] < 0;
    end
    cnd = cfg_motion ? (qa != 0) : (any_en && all_lo);
    det = 0;
    if (rst) begin
      m_cnt = 0; m_ev = 0; m_ax = 0; m_ng = 0;
    end else begin
      if (smp_vld) begin
        if (cnd) begin
          m_cnt = (m_cnt >= int'(dbc_limit)) ? int'(dbc_limit) : m_cnt + 1;
          det = (m_cnt == int'(dbc_limit));
        end else if (cfg_dbclr) m_cnt = 0;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
      end
      if (cfg_latch) begin
        if (smp_vld && det) begin
          if (m_ev && !src_read) begin
            m_ng = (m_ng & ~qa) | na;
            m_ax = m_ax | qa;
          end else begin
            m_ax = qa; m_ng = na;
          end
          m_ev = 1;
        end else if (src_read) begin
          m_ev = 0; m_ax = 0; m_ng = 0;
        end
      end else if (smp_vld) begin
        m_ev = det; m_ax = det ? qa : 3'b0; m_ng = det ? na : 3'b0;
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      checks += 3;
      if (evt_active !== m_ev) begin
        fails++;
        $display("FAIL %s evt_active actual=%0b expected=%0b t=%0t", cur_req, evt_active, m_ev, $time);
      end
      if (src_axis_evt !== m_ax) begin
        fails++;
        $display("FAIL %s src_axis_evt actual=%03b expected=%03b t=%0t", cur_req, src_axis_evt, m_ax, $time);
      end
      if (src_axis_neg !== m_ng) begin
        fails++;
        $display("FAIL %s src_axis_neg actual=%03b expected=%03b t=%0t", cur_req, src_axis_neg, m_ng, $time);
      end
    end
  end

  task automatic smp(input int x, input int y, input int z, input bit rd = 0);
    @(negedge clk);
    smp_vld = 1; sx = 14'(x); sy = 14'(y); sz = 14'(z); src_read = rd;
  endtask

  task automatic idle(input int n, input bit rd = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_vld = 0; src_read = rd;
      sx = 14'($urandom); sy = 14'($urandom); sz = 14'($urandom);
    end
  endtask

  task automatic cfg(input bit mot, input bit [2:0] en, input bit lat, input bit clr,
                     input bit sel, input int tc, input int lim);
    @(negedge clk);
    smp_vld = 0; src_read = 0;
    cfg_motion = mot; cfg_axis_en = en; cfg_latch = lat; cfg_dbclr = clr;
    cfg_thr_sel = sel; thr_common = 7'(tc); dbc_limit = 8'(lim);
  endtask

  function automatic int rnd_smp();
    case ($urandom_range(4))
      0: return -8192;
      1: return int'($urandom_range(16383)) - 8192;
      2: return int'($urandom_range(600)) - 300;
      3: return int'($urandom_range(200)) + 3000;
      default: return -(int'($urandom_range(200)) + 3000);
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cur_req = "R12";
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);

    cur_req = "R1";
    cfg(1, 3'b001, 0, 1, 0, 127, 0);
    smp(-8192, 0, 0); smp(8128, 0, 0); smp(-8191, 0, 0); smp(8191, 0, 0);
    idle(1);

    cur_req = "R2";
    cfg(1, 3'b111, 0, 1, 1, 0, 0);
    thr_x = 100; thr_y = 2000; thr_z = 5000;
    smp(101, 0, 0); smp(0, -2001, 0); smp(100, 2000, 5000); smp(0, 0, -5001);
    cfg(1, 3'b111, 0, 1, 0, 2, 0);
    smp(129, 0, 0); smp(128, 0, 0);

    cur_req = "R3";
    cfg(1, 3'b010, 0, 1, 0, 10, 0);
    smp(8000, 100, -8000); smp(0, -700, 0); smp(0, 641, 0);

    cur_req = "R4";
    cfg(0, 3'b101, 0, 1, 0, 10, 0);
    smp(10, 8000, -10); smp(10, 0, 700); smp(-639, 0, 639); smp(640, 0, 0);
    cfg(0, 3'b000, 0, 1, 0, 10, 0);
    smp(0, 0, 0); smp(0, 0, 0);

    cur_req = "R5";
    cfg(1, 3'b001, 0, 1, 0, 10, 3);
    smp(1000, 0, 0); smp(1000, 0, 0); smp(1000, 0, 0); smp(1000, 0, 0); smp(1000, 0, 0);

    cur_req = "R6";
    cfg(1, 3'b001, 0, 0, 0, 10, 3);
    smp(0, 0, 0); smp(0, 0, 0); smp(1000, 0, 0); smp(0, 0, 0); smp(1000, 0, 0); smp(1000, 0, 0);
    for (int i = 0; i < 6; i++) smp(0, 0, 0);
    smp(1000, 0, 0); smp(1000, 0, 0); smp(1000, 0, 0);

    cur_req = "R7";
    cfg(1, 3'b001, 0, 1, 0, 10, 3);
    smp(0, 0, 0); smp(1000, 0, 0); smp(1000, 0, 0); smp(0, 0, 0); smp(1000, 0, 0); smp(1000, 0, 0); smp(1000, 0, 0);

    cur_req = "R8";
    cfg(1, 3'b111, 1, 1, 0, 10, 0);
    smp(-1000, 0, 0); smp(0, 0, 0); idle(2); smp(0, 0, 0);
    idle(1, 1); idle(1);
    smp(0, 1000, 0); smp(0, 0, -1000, 1); smp(0, 0, 0); idle(1, 1);

    cur_req = "R9";
    cfg(1, 3'b111, 0, 1, 0, 10, 0);
    smp(0, 1000, 0, 1); smp(0, 0, 0, 1); smp(0, -900, 900, 1); idle(1, 1);

    cur_req = "R10";
    cfg(1, 3'b011, 1, 1, 0, 10, 0);
    smp(-1000, 0, 2000); smp(0, 1000, 0); smp(1000, -1000, 0); idle(1, 1);

    cur_req = "R11";
    cfg(1, 3'b001, 0, 0, 0, 10, 2);
    smp(1000, 0, 0); idle(4); smp(1000, 0, 0); idle(3); smp(0, 0, 0);

    cur_req = "R3/R4/R5/R6/R7/R8/R9/R10 random";
    for (int i = 0; i < 8000; i++) begin
      if (i % 40 == 0) begin
        cfg(1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            $urandom_range(70), $urandom_range(4));
        thr_x = 13'($urandom_range(4000)); thr_y = 13'($urandom_range(4000));
        thr_z = 13'($urandom_range(8191));
      end
      if ($urandom_range(9) < 8)
        smp(rnd_smp(), rnd_smp(), rnd_smp(), $urandom_range(9) == 0);
      else
        idle(1, $urandom_range(9) == 0);
    end
    idle(2);

    cur_req = "R12";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; smp_vld = 0; src_read = 0;
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule